// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block converts a 32-bit virtual address into a physical address. It reads a two-level translation table from memory. A requester hands over the virtual address, the table base register and a flag that allows the finest (1 KB) page size. The walker then fetches the first-level descriptor and decodes it. A section ends the walk at once. A table pointer sends the walker to one more fetch, from a coarse or a fine second-level table.

The walk returns one of two outcomes. The first is a physical address with its attributes: page kind, cacheable/bufferable pair, domain and access-permission field. The second is a translation fault. Memory is reached through a one-cycle read request and a later read-valid strobe. The walker waits for each word, so any memory latency works. Only one walk is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high. `busy` is high from the cycle after acceptance through the cycle in which `done` is high. Asserting reset mid-walk returns the block to idle.
- R2: The first read goes to `{base[31:14], va[31:20], 2'b00}`. Bits [13:0] of the base are ignored.
- R3: A first-level descriptor whose bits [1:0] are 00 faults after that single read. A first-level descriptor with bits [1:0] = 11 also faults after one read when `req_tiny_en` was low at acceptance. With `req_tiny_en` high, 11 selects a fine table and 01 selects a coarse table.
- R4: For every non-faulting walk, `domain` equals first-level descriptor bits [8:5].
- R5: Bits [1:0] = 10 mark a section, and the walk ends after one read. The results are `paddr = {d1[31:20], va[19:0]}`, `cb = d1[3:2]` and `perm = {6'b0, d1[11:10]}`.
- R6: For a coarse table, the second read goes to `{d1[31:10], va[19:12], 2'b00}`.
- R7: For a fine table, the second read goes to `{d1[31:12], va[19:10], 2'b00}`.
- R8: A second-level descriptor with bits [1:0] = 00 is a fault. Otherwise `cb` equals second-level bits [3:2].
- R9: A second-level descriptor with bits [1:0] = 01 is a large page, with `paddr = {d2[31:16], va[15:0]}`. A value of 10 is a small page, with `paddr = {d2[31:12], va[11:0]}`. For both, `perm = d2[11:4]`.
- R10: A second-level descriptor with bits [1:0] = 11 is a tiny page, with `paddr = {d2[31:10], va[9:0]}` and `perm = {6'b0, d2[5:4]}`. Bits [11:6] of that descriptor have no effect.
- R11: `ptype` is 0 for a section, 1 for large, 2 for small and 3 for tiny. On a fault, `fault` is 1 and `paddr`, `ptype`, `cb`, `domain` and `perm` are all 0.
- R12: `done` is a one-cycle pulse, and `mem_req` is a one-cycle pulse per read. Results stay unchanged between `done` pulses. With read latency L, `done` is high L+1 cycles after acceptance for a one-read walk and 2L+2 cycles after acceptance for a two-read walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | Translation table base register |
| req_tiny_en | input | 1 | Allow fine tables and tiny pages |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| paddr | output | 32 | Translated physical address |
| ptype | output | 2 | Page kind: 0 section, 1 large, 2 small, 3 tiny |
| cb | output | 2 | Cacheable/bufferable pair |
| domain | output | 4 | Domain number |
| perm | output | 8 | Access-permission field |

## Verification
The memory model answers each read a programmed L cycles after it samples `mem_req`. Each read address is checked on the edge where it is presented. The bench counts clock edges from the acceptance edge to the first sample with `done` high. That count must be L+1 for section or first-level-fault walks and 2L+2 for walks that descend. The result fields are read in that same sample. The following sample confirms that `done` has dropped, `busy` has cleared and the results have held.

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] req_tbase,
  input  logic        req_tiny_en,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [31:0] paddr,
  output logic [1:0]  ptype,
  output logic [1:0]  cb,
  output logic [3:0]  domain,
  output logic [7:0]  perm
);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_FIN} st_t;

  st_t         state;
  logic [31:0] va_q, tb_q, d1_q;
  logic        tiny_q;

  logic        l1_hit, l2_hit, finish, descend;
  logic        nx_fault;
  logic [31:0] nx_pa;
  logic [1:0]  nx_type, nx_cb;
  logic [3:0]  nx_dom;
  logic [7:0]  nx_ap;
  logic [31:0] l1_addr, l2_addr;

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign mem_req   = (state == S_RD1) || (state == S_RD2);

  assign l1_addr  = {tb_q[31:14], va_q[31:20], 2'b00};
  assign l2_addr  = (d1_q[1:0] == 2'b01) ? {d1_q[31:10], va_q[19:12], 2'b00}
                                         : {d1_q[31:12], va_q[19:10], 2'b00};
  assign mem_addr = (state == S_RD1) ? l1_addr :
                    (state == S_RD2) ? l2_addr : 32'd0;

  assign l1_hit = (state == S_WT1) && mem_rvalid;
  assign l2_hit = (state == S_WT2) && mem_rvalid;

  always_comb begin
    finish   = 1'b0;
    descend  = 1'b0;
    nx_fault = 1'b0;
    nx_pa    = 32'd0;
    nx_type  = 2'd0;
    nx_cb    = 2'd0;
    nx_dom   = 4'd0;
    nx_ap    = 8'd0;
    if (l1_hit) begin
      unique case (mem_rdata[1:0])
        2'b10: begin
          finish  = 1'b1;
          nx_pa   = {mem_rdata[31:20], va_q[19:0]};
          nx_type = 2'd0;
          nx_cb   = mem_rdata[3:2];
          nx_dom  = mem_rdata[8:5];
          nx_ap   = {6'd0, mem_rdata[11:10]};
        end
        2'b01:   descend = 1'b1;
        2'b11: begin
          descend  = tiny_q;
          finish   = !tiny_q;
          nx_fault = !tiny_q;
        end
        default: begin
          finish   = 1'b1;
          nx_fault = 1'b1;
        end
      endcase
    end else if (l2_hit) begin
      finish = 1'b1;
      if (mem_rdata[1:0] == 2'b00) begin
        nx_fault = 1'b1;
      end else begin
        nx_type = mem_rdata[1:0] - 2'd1 + 2'd1;
        nx_cb   = mem_rdata[3:2];
        nx_dom  = d1_q[8:5];
        unique case (mem_rdata[1:0])
          2'b01: begin
            nx_type = 2'd1;
            nx_pa   = {mem_rdata[31:16], va_q[15:0]};
            nx_ap   = mem_rdata[11:4];
          end
          2'b10: begin
            nx_type = 2'd2;
            nx_pa   = {mem_rdata[31:12], va_q[11:0]};
            nx_ap   = mem_rdata[11:4];
          end
          default: begin
            nx_type = 2'd3;
            nx_pa   = {mem_rdata[31:10], va_q[9:0]};
            nx_ap   = {6'd0, mem_rdata[5:4]};
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= 32'd0;
      tb_q   <= 32'd0;
      d1_q   <= 32'd0;
      tiny_q <= 1'b0;
      fault  <= 1'b0;
      paddr  <= 32'd0;
      ptype  <= 2'd0;
      cb     <= 2'd0;
      domain <= 4'd0;
      perm   <= 8'd0;
    end else begin
      if (finish) begin
        fault  <= nx_fault;
        paddr  <= nx_pa;
        ptype  <= nx_type;
        cb     <= nx_cb;
        domain <= nx_dom;
        perm   <= nx_ap;
      end
      if (l1_hit) d1_q <= mem_rdata;
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          tb_q   <= req_tbase;
          tiny_q <= req_tiny_en;
          state  <= S_RD1;
        end
        S_RD1:  state <= S_WT1;
        S_WT1:  if (finish) state <= S_FIN; else if (descend) state <= S_RD2;
        S_RD2:  state <= S_WT2;
        S_WT2:  if (finish) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlat_walker_chk.sv
`timescale 1ns/1ps
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [31:0] paddr,
  input logic [1:0]  ptype,
  input logic [1:0]  cb,
  input logic [3:0]  domain,
  input logic [7:0]  perm
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready)) else $error("accept"); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done pulse"); // R12

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req) else $error("mem_req pulse"); // R12

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req) else $error("read while idle"); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(paddr) && $stable(perm) && $stable(fault))) else $error("hold"); // R12

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (paddr == 32'd0 && ptype == 2'd0 && cb == 2'd0 && domain == 4'd0 && perm == 8'd0))
    else $error("fault fields"); // R11

  AST_TINY_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && ptype == 2'd3) |-> (perm[7:2] == 6'd0)) else $error("tiny perm"); // R10

  AST_SECTION_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && ptype == 2'd0) |-> (perm[7:2] == 6'd0)) else $error("section perm"); // R5

endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .busy(busy), .done(done), .fault(fault), .paddr(paddr),
  .ptype(ptype), .cb(cb), .domain(domain), .perm(perm)
);

// File: tb/xlat_walker_tb.sv
`timescale 1ns/1ps
module xlat_walker_tb;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] tb;
    logic        tiny;
    logic [31:0] d1;
    logic [31:0] d2;
    logic [31:0] l1a;
    logic [31:0] l2a;
    logic        flt;
    logic [31:0] pa;
    logic [1:0]  typ;
    logic [1:0]  cb;
    logic [3:0]  dom;
    logic [7:0]  ap;
    logic [1:0]  nrd;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'h8000_7FFF, 1'b0, 32'hABC0_0D4A, 32'h0, 32'h8000_448C, 32'h0, 1'b0, 32'hABC4_5678, 2'd0, 2'd2, 4'hA, 8'h03, 2'd1, 4'd1},
    '{32'h0041_2ABC, 32'h0010_0000, 1'b0, 32'h0020_04A1, 32'h1234_5E56, 32'h0010_0010, 32'h0020_0448, 1'b0, 32'h1234_5ABC, 2'd2, 2'd1, 4'h5, 8'hE5, 2'd2, 4'd2},
    '{32'hFFF8_9ABC, 32'h0000_C000, 1'b0, 32'h3000_0DE1, 32'h7654_03CD, 32'h0000_FFFC, 32'h3000_0E24, 1'b0, 32'h7654_9ABC, 2'd1, 2'd3, 4'hF, 8'h3C, 2'd2, 4'd3},
    '{32'h00A5_6F21, 32'h4000_0000, 1'b1, 32'h0050_3063, 32'h9999_9BEB, 32'h4000_0028, 32'h0050_356C, 1'b0, 32'h9999_9B21, 2'd3, 2'd2, 4'h3, 8'h02, 2'd2, 4'd1},
    '{32'h1000_0000, 32'h0000_0000, 1'b1, 32'hFFFF_FFFC, 32'h0, 32'h0000_0400, 32'h0, 1'b1, 32'h0, 2'd0, 2'd0, 4'h0, 8'h00, 2'd1, 4'd1},
    '{32'h0000_0000, 32'h0000_4000, 1'b0, 32'h0050_3063, 32'h0, 32'h0000_4000, 32'h0, 1'b1, 32'h0, 2'd0, 2'd0, 4'h0, 8'h00, 2'd1, 4'd2},
    '{32'h0000_0000, 32'h0010_0000, 1'b0, 32'h0020_04A1, 32'hFFFF_FFF0, 32'h0010_0000, 32'h0020_0400, 1'b1, 32'h0, 2'd0, 2'd0, 4'h0, 8'h00, 2'd2, 4'd2},
    '{32'hFFFF_FFFF, 32'hFFFF_C000, 1'b1, 32'h0010_0002, 32'h0, 32'hFFFF_FFFC, 32'h0, 1'b0, 32'h001F_FFFF, 2'd0, 2'd0, 4'h0, 8'h00, 2'd1, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = 32'd0;
  logic [31:0] req_tbase = 32'd0;
  logic        req_tiny_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        busy, done, fault;
  logic [31:0] paddr;
  logic [1:0]  ptype, cb;
  logic [3:0]  domain;
  logic [7:0]  perm;

  int   nchk = 0;
  int   nfail = 0;
  bit   finished = 1'b0;
  vec_t cur;
  int   wcnt = 0;
  int   rd_n = 0;

  always #2 clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_tbase(req_tbase), .req_tiny_en(req_tiny_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .paddr(paddr), .ptype(ptype),
    .cb(cb), .domain(domain), .perm(perm)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  assign mem_rvalid = (wcnt == 1);
  assign mem_rdata  = mem_rvalid ? ((rd_n == 0) ? cur.d1 : cur.d2) : 32'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= 0;
      rd_n <= 0;
    end else begin
      if (req_valid && req_ready) rd_n <= 0;
      else if (mem_rvalid) rd_n <= rd_n + 1;
      if (mem_req) begin
        wcnt <= int'(cur.lat);
        if (rd_n == 0)
          chk(mem_addr == cur.l1a, "R2", "first read address", mem_addr, cur.l1a);
        else if (cur.d1[1:0] == 2'b01)
          chk(mem_addr == cur.l2a, "R6", "coarse read address", mem_addr, cur.l2a);
        else
          chk(mem_addr == cur.l2a, "R7", "fine read address", mem_addr, cur.l2a);
      end else if (wcnt != 0) begin
        wcnt <= wcnt - 1;
      end
    end
  end

  task automatic run_vec(input int i, input bit hold_valid);
    int cyc;
    int exp_cyc;
    string rq;
    cur = VECS[i];
    @(negedge clk);
    req_valid   = 1'b1;
    req_vaddr   = cur.va;
    req_tbase   = cur.tb;
    req_tiny_en = cur.tiny;
    @(posedge clk);
    cyc = 0;
    @(negedge clk);
    chk(busy && !req_ready, "R1", "busy after accept", {30'd0, busy, req_ready}, 32'd2);
    if (hold_valid) begin
      req_vaddr   = 32'hFFFF_FFFF;
      req_tbase   = 32'h0;
      req_tiny_en = ~cur.tiny;
    end else begin
      req_valid = 1'b0;
    end
    while (!done && cyc < 200) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    exp_cyc = (cur.nrd == 2'd1) ? int'(cur.lat) + 1 : 2 * int'(cur.lat) + 2;
    chk(cyc == exp_cyc, "R12", "done latency", cyc, exp_cyc);
    chk(rd_n == int'(cur.nrd), cur.flt ? "R3" : "R5", "read count", rd_n, {30'd0, cur.nrd});
    chk(busy, "R1", "busy with done", {31'd0, busy}, 32'd1);
    chk(fault == cur.flt, cur.flt ? "R8" : "R3", "fault flag", {31'd0, fault}, {31'd0, cur.flt});
    rq = cur.flt ? "R11" : (cur.typ == 2'd0) ? "R5" : (cur.typ == 2'd3) ? "R10" : "R9";
    chk(paddr == cur.pa, rq, "paddr", paddr, cur.pa);
    chk(perm == cur.ap, rq, "perm", {24'd0, perm}, {24'd0, cur.ap});
    chk(ptype == cur.typ, "R11", "ptype", {30'd0, ptype}, {30'd0, cur.typ});
    chk(cb == cur.cb, "R8", "cb", {30'd0, cb}, {30'd0, cur.cb});
    chk(domain == cur.dom, "R4", "domain", {28'd0, domain}, {28'd0, cur.dom});
    @(posedge clk);
    @(negedge clk);
    chk(!done && !busy && req_ready, "R12", "idle after done", {29'd0, done, busy, req_ready}, 32'd1);
    chk(paddr == cur.pa, "R12", "paddr held", paddr, cur.pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    cur = VECS[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !busy && !done && !mem_req, "R1", "reset idle",
        {28'd0, req_ready, busy, done, mem_req}, 32'h8);
    chk(paddr == 32'd0 && !fault, "R11", "reset results", paddr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

    // R1: requests offered while busy are not taken
    run_vec(0, 1'b1);
    run_vec(3, 1'b1);

    // R1: reset during a walk
    cur = VECS[2];
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = cur.va;
    req_tbase = cur.tb;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !busy && !mem_req && !done, "R1", "reset mid-walk",
        {28'd0, req_ready, busy, done, mem_req}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(1, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule